// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It owns the command and address pins from reset until the memory is ready for normal traffic. After reset is released it keeps the clock-enable pin low for a programmable settling period. It then raises clock-enable, waits out a NOP window, and walks through the fixed power-up command list. That list contains precharge-all commands, mode-register loads for all four mode registers (with the DLL-reset and off-chip-driver-default variants) and two refreshes.

The contents of the four mode registers come in as live inputs, and the block only decides when to apply them and which bits to force. Every wait between commands is a parameter written in picoseconds or cycles. The block converts each wait to a clock count at elaboration, rounding up against the clock-period parameter. When the sequence is over and the DLL settling count has run out, `init_done` rises. From then on the block holds NOPs on the pins until reset is asserted again.

Top module: `memup_seq`

## Requirements
- R1: While reset is asserted, and for STAB_CYC cycles after it is released, `cke` is 0, `cs_n` is 1 and `init_done` is 0.
- R2: From the cycle `cke` rises, `cke` stays 1. Only NOPs (`cs_n`=0, {`ras_n`,`cas_n`,`we_n`}=111) are driven for ceil(NOP_WIN_PS/CLK_PS) cycles, and then the first precharge-all is issued.
- R3: Commands are encoded on {`ras_n`,`cas_n`,`we_n`} with `cs_n` low: load-mode 000, refresh 001, precharge 010, NOP 111. Exactly eleven non-NOP commands are issued, in this order: precharge-all, load bank 3, load bank 2, load bank 1, load bank 0 (DLL reset), precharge-all, refresh, refresh, load bank 0, load bank 1 (driver default), load bank 1.
- R4: A precharge-all drives `addr` with only bit 10 set and `ba`=0. A refresh drives `addr`=0 and `ba`=0.
- R5: Load-mode addresses are taken from the inputs. Banks 3, 2 and 1 take `emr3_val`, `emr2_val` and `emr1_val` unchanged. The first bank-0 load takes `mr0_val` with bit 8 forced to 1, and the second takes `mr0_val` unchanged. The first of the two later bank-1 loads takes `emr1_val` with bits 9:7 forced to 1, and the last takes `emr1_val` unchanged.
- R6: Each command is followed by NOPs only. The next command is issued exactly 2 cycles after a load-mode, ceil(RP_PS/CLK_PS) cycles after a precharge-all and ceil(RFC_PS/CLK_PS) cycles after a refresh.
- R7: `init_done` first rises in the cycle max(D + DLL_CYC, L + 4), where D is the cycle of the DLL-reset load and L is the cycle of the last load-mode.
- R8: Once `init_done` is 1 it stays 1, `cke` stays 1 and the pins carry NOP until reset.
- R9: A reset asserted in the middle of the sequence returns the block to the R1 state, and after release the whole sequence runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr0_val | input | ADDR_W | Image for mode register 0 |
| emr1_val | input | ADDR_W | Image for extended mode register 1 |
| emr2_val | input | ADDR_W | Image for extended mode register 2 |
| emr3_val | input | ADDR_W | Image for extended mode register 3 |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe command bit |
| cas_n | output | 1 | Column strobe command bit |
| we_n | output | 1 | Write enable command bit |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once initialization is complete |

## Verification
The hardest situation to reach from the ports is a reset that arrives partway through the list, after the DLL counter has been armed and while a refresh wait is running. The bench reaches it by releasing reset, letting the block run into the refresh phase, and then pulling reset again. It then checks that the second run reproduces the complete command list with new mode images. Which of the two paths sets the moment of `init_done` is also hard to see from outside. The bench predicts the rise arithmetically from the observed cycle of the DLL-reset load and of the last load-mode.

// File: rtl/memup_pkg.sv
`timescale 1ns/1ps
package memup_pkg;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_NOP = 3'b111
  } memup_cmd_e;

  typedef enum logic [2:0] {
    PH_STAB  = 3'd0,
    PH_ISSUE = 3'd1,
    PH_GAP   = 3'd2,
    PH_HOLD  = 3'd3,
    PH_DONE  = 3'd4
  } memup_phase_e;

  localparam int STEP_W    = 4;
  localparam int STEP_LAST = 12;
  localparam int STEP_DLL  = 5;
  localparam int MRD_CYC   = 2;

  // Round a picosecond duration up to whole clocks, never below one clock.
  function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
    int q;
    q = t_ps / clk_ps;
    if (q * clk_ps < t_ps) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(input int v);
    int b;
    b = $clog2(v + 1);
    return (b < 1) ? 1 : b;
  endfunction

endpackage

// File: rtl/memup_countdown.sv
`timescale 1ns/1ps
module memup_countdown #(
  parameter int W    = 8,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= W'(INIT);
    else if (load)     cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R6: a running count falls by exactly one per clock
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - W'(1)));

  // R6: an expired count stays at zero until reloaded
  a_r6_count_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/memup_step_decode.sv
`timescale 1ns/1ps
module memup_step_decode
  import memup_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int CNT_W   = 16,
  parameter int NOP_CYC = 54,
  parameter int RP_CYC  = 2,
  parameter int RFC_CYC = 14
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] mr0_i,
  input  logic [ADDR_W-1:0] emr1_i,
  input  logic [ADDR_W-1:0] emr2_i,
  input  logic [ADDR_W-1:0] emr3_i,
  output memup_cmd_e        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  gap_o
);

  // Bit positions the memory decodes: 10 = all banks, 8 = DLL reset, 9:7 = driver default
  localparam logic [ADDR_W-1:0] AP_BIT   = {{(ADDR_W-11){1'b0}}, 11'h400};
  localparam logic [ADDR_W-1:0] DLL_BIT  = {{(ADDR_W-9){1'b0}},  9'h100};
  localparam logic [ADDR_W-1:0] OCD_BITS = {{(ADDR_W-10){1'b0}}, 10'h380};

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    gap_o  = CNT_W'(1);
    case (step_i)
      4'd0: gap_o = CNT_W'(NOP_CYC);
      4'd1, 4'd6: begin
        cmd_o = CMD_PRE; addr_o = AP_BIT; gap_o = CNT_W'(RP_CYC);
      end
      4'd2: begin cmd_o = CMD_LMR; ba_o = BA_W'(3); addr_o = emr3_i;   gap_o = CNT_W'(MRD_CYC); end
      4'd3: begin cmd_o = CMD_LMR; ba_o = BA_W'(2); addr_o = emr2_i;   gap_o = CNT_W'(MRD_CYC); end
      4'd4: begin cmd_o = CMD_LMR; ba_o = BA_W'(1); addr_o = emr1_i;   gap_o = CNT_W'(MRD_CYC); end
      4'd5: begin cmd_o = CMD_LMR; ba_o = BA_W'(0); addr_o = mr0_i | DLL_BIT; gap_o = CNT_W'(MRD_CYC); end
      4'd7, 4'd8: begin cmd_o = CMD_REF; gap_o = CNT_W'(RFC_CYC); end
      4'd9:  begin cmd_o = CMD_LMR; ba_o = BA_W'(0); addr_o = mr0_i;  gap_o = CNT_W'(MRD_CYC); end
      4'd10: begin cmd_o = CMD_LMR; ba_o = BA_W'(1); addr_o = emr1_i | OCD_BITS; gap_o = CNT_W'(MRD_CYC); end
      4'd11: begin cmd_o = CMD_LMR; ba_o = BA_W'(1); addr_o = emr1_i; gap_o = CNT_W'(MRD_CYC); end
      default: ;
    endcase
  end

endmodule

// File: rtl/memup_seq.sv
`timescale 1ns/1ps
module memup_seq
  import memup_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int CLK_PS     = 7500,
  parameter int STAB_CYC   = 26667,
  parameter int NOP_WIN_PS = 400000,
  parameter int RP_PS      = 13125,
  parameter int RFC_PS     = 105000,
  parameter int DLL_CYC    = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mr0_val,
  input  logic [ADDR_W-1:0] emr1_val,
  input  logic [ADDR_W-1:0] emr2_val,
  input  logic [ADDR_W-1:0] emr3_val,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int NOP_CYC = ps_to_cycles(NOP_WIN_PS, CLK_PS);
  localparam int RP_CYC  = ps_to_cycles(RP_PS, CLK_PS);
  localparam int RFC_CYC = ps_to_cycles(RFC_PS, CLK_PS);
  localparam int STAB_C  = (STAB_CYC < 1) ? 1 : STAB_CYC;
  localparam int DLL_C   = (DLL_CYC < 1) ? 1 : DLL_CYC;
  localparam int MAX_GAP = max2(max2(NOP_CYC, STAB_C), max2(RP_CYC, max2(RFC_CYC, MRD_CYC)));
  localparam int CNT_W   = bits_for(MAX_GAP);
  localparam int DLL_W   = bits_for(DLL_C);

  memup_phase_e       phase;
  logic [STEP_W-1:0]  step_idx;

  memup_cmd_e         step_cmd;
  logic [BA_W-1:0]    step_ba;
  logic [ADDR_W-1:0]  step_addr;
  logic [CNT_W-1:0]   step_gap;

  logic [CNT_W-1:0]   gap_cnt;
  logic               gap_zero;
  logic [DLL_W-1:0]   dll_cnt;
  logic               dll_zero;

  // Named internal events
  logic ev_issue, ev_last, ev_dll_arm, ev_short_gap, ev_gap_load, ev_dll_ripe;
  logic [2:0] pin_cmd;

  memup_step_decode #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .NOP_CYC(NOP_CYC), .RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC)
  ) u_decode (
    .step_i(step_idx), .mr0_i(mr0_val), .emr1_i(emr1_val),
    .emr2_i(emr2_val), .emr3_i(emr3_val),
    .cmd_o(step_cmd), .ba_o(step_ba), .addr_o(step_addr), .gap_o(step_gap)
  );

  assign ev_issue     = (phase == PH_ISSUE);
  assign ev_last      = ev_issue && (step_idx == STEP_W'(STEP_LAST));
  assign ev_dll_arm   = ev_issue && (step_idx == STEP_W'(STEP_DLL));
  assign ev_short_gap = (step_gap <= CNT_W'(1));
  assign ev_gap_load  = ev_issue && !ev_last && !ev_short_gap;
  assign ev_dll_ripe  = (dll_cnt <= DLL_W'(1));

  memup_countdown #(.W(CNT_W), .INIT(STAB_C - 1)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(ev_gap_load),
    .load_val(step_gap - CNT_W'(2)), .cnt(gap_cnt), .zero(gap_zero)
  );

  memup_countdown #(.W(DLL_W), .INIT(0)) u_dll (
    .clk(clk), .rst_n(rst_n), .load(ev_dll_arm),
    .load_val(DLL_W'(DLL_C - 1)), .cnt(dll_cnt), .zero(dll_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_STAB;
      step_idx <= '0;
    end else begin
      case (phase)
        PH_STAB: if (gap_zero) begin
          phase    <= PH_ISSUE;
          step_idx <= '0;
        end
        PH_ISSUE: begin
          if (ev_last) phase <= PH_HOLD;
          else if (ev_short_gap) step_idx <= step_idx + STEP_W'(1);
          else phase <= PH_GAP;
        end
        PH_GAP: if (gap_zero) begin
          phase    <= PH_ISSUE;
          step_idx <= step_idx + STEP_W'(1);
        end
        PH_HOLD: if (ev_dll_ripe) phase <= PH_DONE;
        PH_DONE: phase <= PH_DONE;
        default: phase <= PH_STAB;
      endcase
    end
  end

  assign pin_cmd   = ev_issue ? step_cmd : CMD_NOP;
  assign cke       = (phase != PH_STAB);
  assign cs_n      = (phase == PH_STAB);
  assign ras_n     = pin_cmd[2];
  assign cas_n     = pin_cmd[1];
  assign we_n      = pin_cmd[0];
  assign ba        = ev_issue ? step_ba : '0;
  assign addr      = ev_issue ? step_addr : '0;
  assign init_done = (phase == PH_DONE);

  // R1: with the clock enable low the device is deselected and not ready
  a_r1_stab_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cs_n && !init_done));

  // R4: a precharge on the pins always selects all banks
  a_r4_prea_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && {ras_n, cas_n, we_n} == 3'b010) |-> (addr[10] && ba == '0));

  // R6: a load-mode is followed by a NOP in the next cycle
  a_r6_mrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && {ras_n, cas_n, we_n} == 3'b000) |=> (cs_n || {ras_n, cas_n, we_n} == 3'b111));

  // R7: readiness never precedes the end of the DLL settle count
  a_r7_dll_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> dll_zero);

  // R8: ready is sticky and keeps the pins quiet
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && cke && !cs_n && {ras_n, cas_n, we_n} == 3'b111));

endmodule

// File: tb/memup_seq_tb.sv
`timescale 1ns/1ps
module memup_seq_tb;

  localparam real TCK_NS = 7.5;
  localparam int  TCK_PS = 7500;
  localparam int  STAB   = 10;
  localparam int  NOPWIN = 400000;
  localparam int  RPPS   = 13125;
  localparam int  RFCPS  = 105000;
  localparam int  DLL    = 200;
  localparam int  NS     = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] mr0_val = '0, emr1_val = '0, emr2_val = '0, emr3_val = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [12:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(TCK_NS / 2.0) clk = ~clk;

  memup_seq #(
    .ADDR_W(13), .BA_W(2), .CLK_PS(TCK_PS), .STAB_CYC(STAB),
    .NOP_WIN_PS(NOPWIN), .RP_PS(RPPS), .RFC_PS(RFCPS), .DLL_CYC(DLL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mr0_val(mr0_val), .emr1_val(emr1_val),
    .emr2_val(emr2_val), .emr3_val(emr3_val), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done)
  );

  function automatic int up_div(input int t, input int c);
    return (t + c - 1) / c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected list: wait in cycles after step s, command, bank and address
  function automatic int gap_of(input int s);
    case (s)
      0: return up_div(NOPWIN, TCK_PS);
      1, 6: return up_div(RPPS, TCK_PS);
      7, 8: return up_div(RFCPS, TCK_PS);
      default: return 2;
    endcase
  endfunction

  function automatic logic [2:0] cmd_of(input int s);
    case (s)
      1, 6: return 3'b010;
      7, 8: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int ba_of(input int s);
    case (s)
      2: return 3;
      3: return 2;
      4, 10, 11: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [12:0] addr_of(input int s, input logic [12:0] m0, e1, e2, e3);
    case (s)
      1, 6: return 13'd1024;
      2: return e3;
      3: return e2;
      4, 11: return e1;
      5: return m0 + ((m0 & 13'h100) == 0 ? 13'h100 : 13'h0);
      9: return m0;
      10: return e1 | 13'h380;
      default: return 13'h0;
    endcase
  endfunction

  task automatic run_pass(input logic [12:0] m0, e1, e2, e3, input string tag);
    logic        s_cke[NS], s_csn[NS], s_done[NS];
    logic [2:0]  s_cmd[NS];
    logic [1:0]  s_ba[NS];
    logic [12:0] s_addr[NS];
    int ev_cyc[16];
    logic [2:0] ev_cmd[16];
    int ev_ba[16];
    logic [12:0] ev_addr[16];
    int nev, c, cdll, clast, done_at, exp_done, bad;
    mr0_val = m0; emr1_val = e1; emr2_val = e2; emr3_val = e3;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1, R9: reset state
    chk(!cke && cs_n && !init_done, "R1", {tag, " reset state"}, {cke, cs_n, init_done}, 3'b010);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NS; k++) begin
      #1;
      s_cke[k] = cke; s_csn[k] = cs_n; s_done[k] = init_done;
      s_cmd[k] = {ras_n, cas_n, we_n}; s_ba[k] = ba; s_addr[k] = addr;
      @(negedge clk);
    end
    bad = 0;
    for (int k = 0; k < STAB; k++)
      if (s_cke[k] || !s_csn[k] || s_done[k]) bad++;
    chk(bad == 0, "R1", {tag, " settle window samples wrong"}, bad, 0);
    chk(s_cke[STAB] == 1'b1, "R1", {tag, " cke rises after settle"}, s_cke[STAB], 1);
    nev = 0; bad = 0; done_at = -1;
    for (int k = STAB; k < NS; k++) begin
      if (!s_cke[k] || s_csn[k]) bad++;
      if (!s_csn[k] && s_cmd[k] != 3'b111) begin
        if (nev < 16) begin
          ev_cyc[nev] = k; ev_cmd[nev] = s_cmd[k]; ev_ba[nev] = s_ba[k]; ev_addr[nev] = s_addr[k];
        end
        nev++;
      end
      if (s_done[k] && done_at < 0) done_at = k;
    end
    chk(bad == 0, "R2", {tag, " cke held high and selected"}, bad, 0);
    chk(nev == 11, "R3", {tag, " command count"}, nev, 11);
    c = STAB;
    cdll = 0; clast = 0;
    for (int s = 1; s <= 11; s++) begin
      c = c + gap_of(s - 1);
      if (s == 5) cdll = c;
      clast = c;
      if (s - 1 < nev && s - 1 < 16) begin
        // R2 (first), R6 (rest): exact issue cycles
        chk(ev_cyc[s-1] == c, (s == 1) ? "R2" : "R6", $sformatf("%s step %0d cycle", tag, s), ev_cyc[s-1], c);
        chk(ev_cmd[s-1] == cmd_of(s), "R3", $sformatf("%s step %0d command", tag, s), ev_cmd[s-1], cmd_of(s));
        chk(ev_ba[s-1] == ba_of(s), "R3", $sformatf("%s step %0d bank", tag, s), ev_ba[s-1], ba_of(s));
        chk(ev_addr[s-1] == addr_of(s, m0, e1, e2, e3), (cmd_of(s) == 3'b000) ? "R5" : "R4",
            $sformatf("%s step %0d address", tag, s), ev_addr[s-1], addr_of(s, m0, e1, e2, e3));
      end
    end
    // R7: done rise: last load at clast, final NOP 2 later, done 2 after that
    exp_done = (cdll + DLL > clast + 4) ? cdll + DLL : clast + 4;
    chk(done_at == exp_done, "R7", {tag, " init_done rise cycle"}, done_at, exp_done);
    bad = 0;
    if (done_at >= 0)
      for (int k = done_at; k < NS; k++)
        if (!s_done[k] || !s_cke[k] || s_csn[k] || s_cmd[k] != 3'b111) bad++;
    chk(done_at >= 0 && bad == 0, "R8", {tag, " done sticky with NOP"}, bad, 0);
  endtask

  initial begin
    run_pass(13'h0a52, 13'h0044, 13'h0080, 13'h1001, "pass1");
    // R9: restart from the middle of the refresh phase
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (STAB + 70) @(negedge clk);
    #1;
    chk(cke && !init_done, "R9", "mid-sequence before reset", {cke, init_done}, 2'b10);
    run_pass(13'h1f00, 13'h0402, 13'h0123, 13'h0000, "R9 restart");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule